// File: doc/BRIEF.md
# Annotated Snoop Dispatch Filter

This block sits on a core's data-cache miss path, in front of the shared snoop queue. For each miss it decides which of the other cores must receive a snoop probe. It writes one queue entry per miss, and that entry carries a per-core probe mask. The decision uses three inputs:

- two annotation bits that travel with the miss: a stack bit from the front end and a "do not snoop me" bit;
- a software control bit that says whether the running code may modify itself;
- for ordinary (non-stack) misses, the result of a counting Bloom filter lookup.

A miss enters through a valid/ready handshake. It is accepted only while the snoop queue can take an entry. It then waits in a single pipeline register while the Bloom filter answers one cycle later. It leaves as a queue entry through a second valid/ready handshake.

An entry whose probes are all suppressed is still written, flagged as carrying no probe, so that the queue stays in order. Stores additionally request an instruction-cache snoop unless software has declared the code static. Three counters record how many entries were suppressed, one counter for each reason.

Top module: `snoop_dispatch_filter`

## Requirements
- R1: `inReady` equals `qReady`. A miss taken on a rising edge appears as `qValid`=1 in the cycle that follows, carrying the same `qCore` and `qAddr`.
- R2: A miss with `inNoSnoop`=1 produces `qMask`=0. This holds whatever its stack bit and filter result are, and it is counted only in `cntNoSnoop`.
- R3: A miss with `inNoSnoop`=0 and `inStack`=1 produces `qMask`=0, whatever the filter result is, and is counted in `cntStack`.
- R4: A miss with both annotation bits 0 is probed only when `bfHit` is 1. Then `qMask` has every core bit set except the requester's. A filter miss gives `qMask`=0 and is counted in `cntFilter`.
- R5: Bit `qCore` of `qMask` is always 0 while `qValid` is 1.
- R6: Every accepted miss produces an entry, including suppressed ones. `qNoProbe` is 1 exactly when `qMask` is 0. An entry stays on the outputs, unchanged, while `qReady` is 0.
- R7: `qIcSnoop` is 1 exactly when the miss is a store (`inStore`=1) and `codeStatic` was 0 when the miss was accepted. `codeStatic`=1 means the code is not self-modifying.
- R8: `bfRdEn` is 1, with `bfRdAddr` equal to `inAddr`, exactly when a miss with both annotation bits 0 is being accepted. `bfHit` is sampled in the next cycle and held for the rest of the stall.
- R9: Each suppression counter rises by exactly one when a suppressed entry of its reason leaves (`qValid` and `qReady` both 1), and by no more than one per cycle.
- R10: After reset `qValid` is 0 and all three counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Miss request valid |
| inReady | output | 1 | Miss request accepted this cycle |
| inCore | input | CORE_W | Index of the requesting core |
| inAddr | input | ADDR_W | Line address of the miss |
| inStore | input | 1 | Miss was caused by a store |
| inStack | input | 1 | Front-end stack annotation |
| inNoSnoop | input | 1 | Do-not-snoop annotation |
| codeStatic | input | 1 | 1: code is not self-modifying |
| bfRdEn | output | 1 | Bloom filter lookup strobe |
| bfRdAddr | output | ADDR_W | Bloom filter lookup address |
| bfHit | input | 1 | Filter result, one cycle after the lookup |
| qValid | output | 1 | Queue entry valid |
| qReady | input | 1 | Snoop queue not full |
| qCore | output | CORE_W | Requesting core of the entry |
| qAddr | output | ADDR_W | Line address of the entry |
| qMask | output | N_CORES | One probe bit per core |
| qNoProbe | output | 1 | Entry carries no data probe |
| qIcSnoop | output | 1 | Entry requests an instruction-cache snoop |
| cntStack | output | CNT_W | Entries suppressed by the stack bit |
| cntNoSnoop | output | CNT_W | Entries suppressed by the do-not-snoop bit |
| cntFilter | output | CNT_W | Entries suppressed by a filter miss |

## Verification
The bench drives misses that set both annotation bits and also see a filter hit. A design that ranked the stack bit above the do-not-snoop bit would send those misses to the wrong counter.

The bench also varies the requester across all four cores. A mask built with a fixed core, or without clearing the requester's own bit, shows up there as a wrong bit.

A directed stall holds the entry while the filter input changes. A design that read `bfHit` live, rather than holding it, would flip the mask during that stall. The same test offers a new miss while the queue is full, to catch a design that lets it in early or drops it.

// File: rtl/snoop_filter_pkg.sv
package snoop_filter_pkg;

  // Reason an entry carries no data probe; ordered by precedence.
  typedef enum logic [1:0] {
    RSN_NOSNOOP = 2'd0,
    RSN_STACK   = 2'd1,
    RSN_FILTER  = 2'd2,
    RSN_NONE    = 2'd3
  } reason_e;

  localparam int N_REASONS = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture a new miss into the stage
    logic drain;  // the stage entry leaves this cycle
    logic fresh;  // filter answer for the stage arrives this cycle
  } stage_ctl_t;

endpackage

// File: rtl/snoop_filter_ctrl.sv
module snoop_filter_ctrl
  import snoop_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       qReady,
  output logic       inReady,
  output logic       qValid,
  output stage_ctl_t ctl
);

  logic stageValid;
  logic freshQ;

  assign inReady   = qReady;
  assign ctl.load  = inValid && qReady;
  assign ctl.drain = stageValid && qReady;
  assign ctl.fresh = freshQ;
  assign qValid    = stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      freshQ     <= 1'b0;
    end else begin
      freshQ <= ctl.load;
      if (ctl.load)       stageValid <= 1'b1;
      else if (ctl.drain) stageValid <= 1'b0;
    end
  end

  // R1
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> qValid);

  // R6
  stall_holds_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qValid && !qReady) |=> qValid);

endmodule

// File: rtl/snoop_filter_dp.sv
module snoop_filter_dp
  import snoop_filter_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stage_ctl_t        ctl,
  input  logic              qValid,
  input  logic              qReady,
  input  logic [CORE_W-1:0] inCore,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inStore,
  input  logic              inStack,
  input  logic              inNoSnoop,
  input  logic              codeStatic,
  input  logic              bfHit,
  output logic              bfRdEn,
  output logic [ADDR_W-1:0] bfRdAddr,
  output logic [CORE_W-1:0] qCore,
  output logic [ADDR_W-1:0] qAddr,
  output logic [N_CORES-1:0] qMask,
  output logic              qNoProbe,
  output logic              qIcSnoop,
  output logic [CNT_W-1:0]  cntStack,
  output logic [CNT_W-1:0]  cntNoSnoop,
  output logic [CNT_W-1:0]  cntFilter
);

  logic [CORE_W-1:0] stgCore;
  logic [ADDR_W-1:0] stgAddr;
  logic              stgStore;
  logic              stgStack;
  logic              stgNoSnoop;
  logic              stgStatic;
  logic              hitHeld;
  logic              hitNow;
  logic              probeOn;
  reason_e           reason;
  logic [CNT_W-1:0]  cnt [N_REASONS];

  // Filter lookup only for misses that reach the filter stage of the decision.
  assign bfRdEn   = ctl.load && !inStack && !inNoSnoop;
  assign bfRdAddr = inAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgCore    <= '0;
      stgAddr    <= '0;
      stgStore   <= 1'b0;
      stgStack   <= 1'b0;
      stgNoSnoop <= 1'b0;
      stgStatic  <= 1'b0;
      hitHeld    <= 1'b0;
    end else begin
      if (ctl.fresh) hitHeld <= bfHit;
      if (ctl.load) begin
        stgCore    <= inCore;
        stgAddr    <= inAddr;
        stgStore   <= inStore;
        stgStack   <= inStack;
        stgNoSnoop <= inNoSnoop;
        stgStatic  <= codeStatic;
      end
    end
  end

  assign hitNow = ctl.fresh ? bfHit : hitHeld;

  always_comb begin
    if (stgNoSnoop)   reason = RSN_NOSNOOP;
    else if (stgStack) reason = RSN_STACK;
    else if (!hitNow)  reason = RSN_FILTER;
    else               reason = RSN_NONE;
  end

  assign probeOn = (reason == RSN_NONE);

  for (genvar c = 0; c < N_CORES; c++) begin : g_mask
    assign qMask[c] = probeOn && (stgCore != CORE_W'(c));
  end

  assign qCore    = stgCore;
  assign qAddr    = stgAddr;
  assign qNoProbe = !probeOn;
  assign qIcSnoop = stgStore && !stgStatic;

  for (genvar r = 0; r < N_REASONS; r++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN)
        cnt[r] <= '0;
      else if (ctl.drain && (reason == reason_e'(r)))
        cnt[r] <= cnt[r] + 1'b1;
    end
  end

  assign cntNoSnoop = cnt[RSN_NOSNOOP];
  assign cntStack   = cnt[RSN_STACK];
  assign cntFilter  = cnt[RSN_FILTER];

  // R5
  own_bit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    qValid |-> !qMask[qCore]);

  // R2
  nosnoop_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qValid && stgNoSnoop) |-> (qMask == '0));

  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qValid && !qReady) |=> ($stable(qMask) && $stable(qCore) && $stable(qAddr)));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ##1 ((cntStack - $past(cntStack)) <= CNT_W'(1)) &&
        ((cntNoSnoop - $past(cntNoSnoop)) <= CNT_W'(1)) &&
        ((cntFilter - $past(cntFilter)) <= CNT_W'(1)));

endmodule

// File: rtl/snoop_dispatch_filter.sv
module snoop_dispatch_filter
  import snoop_filter_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [CORE_W-1:0]  inCore,
  input  logic [ADDR_W-1:0]  inAddr,
  input  logic               inStore,
  input  logic               inStack,
  input  logic               inNoSnoop,
  input  logic               codeStatic,
  output logic               bfRdEn,
  output logic [ADDR_W-1:0]  bfRdAddr,
  input  logic               bfHit,
  output logic               qValid,
  input  logic               qReady,
  output logic [CORE_W-1:0]  qCore,
  output logic [ADDR_W-1:0]  qAddr,
  output logic [N_CORES-1:0] qMask,
  output logic               qNoProbe,
  output logic               qIcSnoop,
  output logic [CNT_W-1:0]   cntStack,
  output logic [CNT_W-1:0]   cntNoSnoop,
  output logic [CNT_W-1:0]   cntFilter
);

  stage_ctl_t ctl;

  snoop_filter_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .qReady  (qReady),
    .inReady (inReady),
    .qValid  (qValid),
    .ctl     (ctl)
  );

  snoop_filter_dp #(
    .N_CORES (N_CORES),
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .qValid     (qValid),
    .qReady     (qReady),
    .inCore     (inCore),
    .inAddr     (inAddr),
    .inStore    (inStore),
    .inStack    (inStack),
    .inNoSnoop  (inNoSnoop),
    .codeStatic (codeStatic),
    .bfHit      (bfHit),
    .bfRdEn     (bfRdEn),
    .bfRdAddr   (bfRdAddr),
    .qCore      (qCore),
    .qAddr      (qAddr),
    .qMask      (qMask),
    .qNoProbe   (qNoProbe),
    .qIcSnoop   (qIcSnoop),
    .cntStack   (cntStack),
    .cntNoSnoop (cntNoSnoop),
    .cntFilter  (cntFilter)
  );

endmodule

// File: tb/snoop_dispatch_filter_tb.sv
module snoop_dispatch_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int AW = 32;
  localparam int CWD = 16;

  typedef struct packed {
    logic [1:0] core;
    logic       st;
    logic       sk;
    logic       ns;
    logic       cs;
    logic       hit;
    logic [3:0] mask;
    logic       np;
    logic       ic;
    logic       rd;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1110, 1'b0, 1'b0, 1'b1},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1101, 1'b0, 1'b1, 1'b1},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b0},
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b0},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0111, 1'b0, 1'b0, 1'b1},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1011, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] inCore = '0;
  logic [AW-1:0] inAddr = '0;
  logic inStore = 1'b0;
  logic inStack = 1'b0;
  logic inNoSnoop = 1'b0;
  logic codeStatic = 1'b1;
  logic bfRdEn;
  logic [AW-1:0] bfRdAddr;
  logic bfHit = 1'b0;
  logic qValid;
  logic qReady = 1'b1;
  logic [1:0] qCore;
  logic [AW-1:0] qAddr;
  logic [NC-1:0] qMask;
  logic qNoProbe;
  logic qIcSnoop;
  logic [CWD-1:0] cntStack;
  logic [CWD-1:0] cntNoSnoop;
  logic [CWD-1:0] cntFilter;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_dispatch_filter #(.N_CORES(NC), .ADDR_W(AW), .CNT_W(CWD)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCore(inCore), .inAddr(inAddr), .inStore(inStore), .inStack(inStack),
    .inNoSnoop(inNoSnoop), .codeStatic(codeStatic), .bfRdEn(bfRdEn),
    .bfRdAddr(bfRdAddr), .bfHit(bfHit), .qValid(qValid), .qReady(qReady),
    .qCore(qCore), .qAddr(qAddr), .qMask(qMask), .qNoProbe(qNoProbe),
    .qIcSnoop(qIcSnoop), .cntStack(cntStack), .cntNoSnoop(cntNoSnoop),
    .cntFilter(cntFilter)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [AW-1:0] a, input logic st,
                       input logic sk, input logic ns, input logic cs);
    inValid = 1'b1; inCore = c; inAddr = a; inStore = st;
    inStack = sk; inNoSnoop = ns; codeStatic = cs;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    check(qValid == 1'b0, "R10 qValid", 64'(qValid), 0);
    check(cntStack == 0 && cntNoSnoop == 0 && cntFilter == 0, "R10 counters",
          64'({cntStack, cntNoSnoop, cntFilter}), 0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [AW-1:0] addr;
      v = VECS[i];
      addr = AW'(32'h1000 + i * 64);
      @(negedge clk);
      drive(v.core, addr, v.st, v.sk, v.ns, v.cs);
      #1;
      // R8 filter lookup strobe
      check(bfRdEn == v.rd, "R8 bfRdEn", 64'(bfRdEn), 64'(v.rd));
      if (v.rd) check(bfRdAddr == addr, "R8 bfRdAddr", 64'(bfRdAddr), 64'(addr));
      // R1 ready follows queue space
      check(inReady == 1'b1, "R1 inReady", 64'(inReady), 1);
      @(posedge clk);
      #1;
      inValid = 1'b0;
      bfHit = v.hit;
      @(negedge clk);
      check(qValid && qCore == v.core && qAddr == addr, "R1 entry",
            64'({qValid, qCore}), 64'({1'b1, v.core}));
      // R2 R3 R4 R5 mask by precedence, own bit clear
      check(qMask == v.mask, "R4 R2 R3 R5 qMask", 64'(qMask), 64'(v.mask));
      // R6 no-probe flag
      check(qNoProbe == v.np, "R6 qNoProbe", 64'(qNoProbe), 64'(v.np));
      // R7 icache snoop
      check(qIcSnoop == v.ic, "R7 qIcSnoop", 64'(qIcSnoop), 64'(v.ic));
      @(posedge clk);
      #1;
      bfHit = 1'b0;
    end
    @(negedge clk);
    check(qValid == 1'b0, "R6 drained", 64'(qValid), 0);
    // R9 per-reason counts from the table: nosnoop 2, stack 2, filter 1
    check(cntNoSnoop == 2, "R9 cntNoSnoop R2", 64'(cntNoSnoop), 2);
    check(cntStack == 2, "R9 cntStack R3", 64'(cntStack), 2);
    check(cntFilter == 1, "R9 cntFilter R4", 64'(cntFilter), 1);

    // Stall: filter answer held, entry kept, new miss blocked
    @(negedge clk);
    drive(2'd0, 32'hABC0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk);
    #1;
    inValid = 1'b0;
    bfHit = 1'b1;
    @(negedge clk);
    qReady = 1'b0;
    #1;
    check(inReady == 1'b0, "R1 blocked when full", 64'(inReady), 0);
    @(posedge clk);
    #1;
    bfHit = 1'b0;
    @(negedge clk);
    drive(2'd1, 32'hDEF0, 1'b0, 1'b1, 1'b0, 1'b1);
    #1;
    check(qValid && qMask == 4'b1110, "R8 hit held in stall", 64'(qMask), 64'hE);
    check(qAddr == 32'hABC0, "R6 entry stable", 64'(qAddr), 64'hABC0);
    @(posedge clk);
    @(negedge clk);
    check(qAddr == 32'hABC0 && qMask == 4'b1110, "R6 still held", 64'(qAddr), 64'hABC0);
    qReady = 1'b1;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    @(negedge clk);
    check(qValid && qCore == 2'd1 && qAddr == 32'hDEF0, "R1 next entry",
          64'(qAddr), 64'hDEF0);
    check(qMask == 4'b0000 && qNoProbe, "R3 stack entry", 64'(qMask), 0);
    @(posedge clk);
    @(negedge clk);
    check(cntStack == 3, "R9 cntStack after stall", 64'(cntStack), 3);
    check(cntFilter == 1 && cntNoSnoop == 2, "R9 others unchanged",
          64'({cntFilter, cntNoSnoop}), 64'({16'd1, 16'd2}));
    check(qValid == 1'b0, "R6 empty", 64'(qValid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule